// File: doc/BRIEF.md
# Byte Parity Generator and Checker

This block sits between a 16-bit memory data path and an 18-bit wide RAM. On the write side it adds one odd parity bit to each data byte, so the stored word holds 16 data bits and 2 check bits. On the read side it recomputes parity for both bytes of the word returned by the RAM, and reports any mismatch in-band on the two extra bus data lines, bits 16 and 17. Both paths are registered, with one cycle of latency.

A diagnostic control inverts the generated parity so that software can plant known-bad words. A separate control masks error reporting, so that words with bad check bits still read back with clean flag lines. A byte write enables only the lane being written, so the parity bit of the other byte in RAM is not changed.

Top module: `byte_parity_unit`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `ram_wr_data`, `ram_wr_be`, `bus_data` and `bus_valid` are all zero.
- R2: One cycle after a word write (`wr_en`=1, `wr_byte`=0) with `par_invert`=0, `ram_wr_data[15:0]` equals `wr_data`, bit 16 makes bits 7:0 plus bit 16 hold an odd count of ones, bit 17 does the same for bits 15:8, and `ram_wr_be` is 2'b11.
- R3: One cycle after a byte write (`wr_byte`=1), `ram_wr_be` is 2'b01 for `wr_lane`=0 (bits 7:0) and 2'b10 for `wr_lane`=1 (bits 15:8). The parity bits are computed as in R2.
- R4: With `par_invert`=1 on a write, both stored parity bits are the inverse of their R2 values, giving even parity in each lane.
- R5: One cycle after `rd_valid`=1, `bus_valid` is 1 and `bus_data[15:0]` equals `ram_rd_data[15:0]`, whether or not parity is bad.
- R6: If `err_mask`=0 on a read and either lane of `ram_rd_data` (bits 7:0 with 16, or bits 15:8 with 17) holds an even count of ones, then `bus_data[17:16]` is 2'b11 one cycle later. If neither lane does, it is 2'b00.
- R7: With `err_mask`=1 on a read, `bus_data[17:16]` is 2'b00 one cycle later, even when parity is bad.
- R8: One cycle after a cycle with `wr_en`=0, `ram_wr_data` and `ram_wr_be` are zero. One cycle after a cycle with `rd_valid`=0, `bus_data` and `bus_valid` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write request this cycle |
| wr_byte | input | 1 | 1 = single-byte write, 0 = full word |
| wr_lane | input | 1 | Byte lane for a byte write (0 = bits 7:0) |
| wr_data | input | 16 | Write data |
| par_invert | input | 1 | Diagnostic: store inverted parity |
| err_mask | input | 1 | Suppress error flags on reads |
| ram_wr_data | output | 18 | Word to RAM: data plus parity in bits 17:16 |
| ram_wr_be | output | 2 | Per-lane RAM write enables |
| rd_valid | input | 1 | RAM read data valid this cycle |
| ram_rd_data | input | 18 | Word returned by RAM |
| bus_data | output | 18 | Read data to bus, error flags in bits 17:16 |
| bus_valid | output | 1 | `bus_data` holds a read result |

## Verification
The properties assume that the control inputs are at known levels whenever reset is released. They also assume that `wr_lane` is meaningful only on a byte write, and that a read and a write may occur in the same cycle without interfering. The stimulus drives every input at the falling edge, holds it for a full cycle, and returns the controls to zero between operations. Read words are built with parity that is known to be good or bad, so each mismatch case, including one bad lane and both bad lanes, is deliberate.

// File: rtl/par_pkg.sv
package par_pkg;

    localparam int unsigned LANE_W_DEF = 8;
    localparam int unsigned LANES_DEF  = 2;

    // kind of write presented in a cycle
    typedef enum logic [1:0] {
        WK_NONE = 2'd0,
        WK_FULL = 2'd1,
        WK_LANE = 2'd2
    } wr_kind_e;

endpackage

// File: rtl/par_gen.sv
module par_gen #(
    parameter int unsigned LANE_W = 8,
    parameter int unsigned LANES  = 2,
    localparam int unsigned DATA_W = LANE_W * LANES
) (
    input  logic [DATA_W-1:0] data,
    input  logic              invert,
    output logic [LANES-1:0]  par
);

    // odd parity per lane, flipped in diagnostic mode
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign par[i] = ~(^data[i*LANE_W +: LANE_W]) ^ invert;
    end

endmodule

// File: rtl/par_chk.sv
module par_chk #(
    parameter int unsigned LANE_W = 8,
    parameter int unsigned LANES  = 2,
    localparam int unsigned DATA_W = LANE_W * LANES
) (
    input  logic [DATA_W-1:0] data,
    input  logic [LANES-1:0]  par,
    output logic [LANES-1:0]  mism
);

    // a lane is good when data plus check bit hold an odd count of ones
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign mism[i] = ~(^{par[i], data[i*LANE_W +: LANE_W]});
    end

endmodule

// File: rtl/be_dec.sv
module be_dec
    import par_pkg::*;
#(
    parameter int unsigned LANES = 2,
    localparam int unsigned LSEL_W = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  wr_kind_e          kind,
    input  logic [LSEL_W-1:0] lane,
    output logic [LANES-1:0]  be
);

    for (genvar i = 0; i < LANES; i++) begin : g_be
        assign be[i] = (kind == WK_FULL) ||
                       ((kind == WK_LANE) && (lane == LSEL_W'(i)));
    end

endmodule

// File: rtl/byte_parity_unit.sv
module byte_parity_unit
    import par_pkg::*;
#(
    parameter int unsigned LANE_W = LANE_W_DEF,
    parameter int unsigned LANES  = LANES_DEF,
    localparam int unsigned DATA_W = LANE_W * LANES,
    localparam int unsigned WORD_W = DATA_W + LANES,
    localparam int unsigned LSEL_W = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_byte,
    input  logic [LSEL_W-1:0] wr_lane,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              par_invert,
    input  logic              err_mask,
    output logic [WORD_W-1:0] ram_wr_data,
    output logic [LANES-1:0]  ram_wr_be,
    input  logic              rd_valid,
    input  logic [WORD_W-1:0] ram_rd_data,
    output logic [WORD_W-1:0] bus_data,
    output logic              bus_valid
);

    typedef struct packed {
        logic [WORD_W-1:0] wr_word;
        logic [LANES-1:0]  wr_be;
        logic [WORD_W-1:0] rd_word;
        logic              rd_vld;
    } state_t;

    state_t   st_d, st_q;
    wr_kind_e kind_d;
    logic [LANES-1:0] gen_par_d;
    logic [LANES-1:0] be_d;
    logic [LANES-1:0] mism_d;

    assign kind_d = !wr_en  ? WK_NONE :
                    wr_byte ? WK_LANE : WK_FULL;

    par_gen #(.LANE_W(LANE_W), .LANES(LANES)) i_gen (
        .data   (wr_data),
        .invert (par_invert),
        .par    (gen_par_d)
    );

    be_dec #(.LANES(LANES)) i_be (
        .kind (kind_d),
        .lane (wr_lane),
        .be   (be_d)
    );

    par_chk #(.LANE_W(LANE_W), .LANES(LANES)) i_chk (
        .data (ram_rd_data[DATA_W-1:0]),
        .par  (ram_rd_data[WORD_W-1:DATA_W]),
        .mism (mism_d)
    );

    always_comb begin
        st_d = '0;
        if (wr_en) begin
            st_d.wr_word = {gen_par_d, wr_data};
            st_d.wr_be   = be_d;
        end
        if (rd_valid) begin
            st_d.rd_vld                  = 1'b1;
            st_d.rd_word[DATA_W-1:0]     = ram_rd_data[DATA_W-1:0];
            st_d.rd_word[WORD_W-1:DATA_W] = {LANES{(|mism_d) & ~err_mask}};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ram_wr_data = st_q.wr_word;
    assign ram_wr_be   = st_q.wr_be;
    assign bus_data    = st_q.rd_word;
    assign bus_valid   = st_q.rd_vld;

    // ---------------- assertions ----------------
    assert_word_be_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_byte) |=> (ram_wr_be == {LANES{1'b1}}));

    assert_word_odd_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !par_invert) |=> (^{ram_wr_data[DATA_W], ram_wr_data[LANE_W-1:0]}));

    assert_lane_be_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_byte) |=> ($countones(ram_wr_be) == 1));

    assert_inv_even_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && par_invert) |=> !(^{ram_wr_data[DATA_W], ram_wr_data[LANE_W-1:0]}));

    assert_read_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> (bus_valid && bus_data[DATA_W-1:0] == $past(ram_rd_data[DATA_W-1:0])));

    assert_mask_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && err_mask) |=> (bus_data[WORD_W-1:DATA_W] == '0));

    assert_idle_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |=> (!bus_valid && bus_data == '0));

    assert_idle_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (ram_wr_be == '0 && ram_wr_data == '0));

endmodule

// File: tb/test_byte_parity_unit.sv
`timescale 1ns/1ps
module test_byte_parity_unit;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en, wr_byte, wr_lane, par_invert, err_mask, rd_valid;
    logic [15:0] wr_data;
    logic [17:0] ram_rd_data;
    logic [17:0] ram_wr_data, bus_data;
    logic [1:0]  ram_wr_be;
    logic        bus_valid;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    byte_parity_unit i_byte_parity_unit (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_byte(wr_byte),
        .wr_lane(wr_lane), .wr_data(wr_data), .par_invert(par_invert),
        .err_mask(err_mask), .ram_wr_data(ram_wr_data), .ram_wr_be(ram_wr_be),
        .rd_valid(rd_valid), .ram_rd_data(ram_rd_data),
        .bus_data(bus_data), .bus_valid(bus_valid)
    );

    // vector: {invert, byte, lane, data}
    localparam logic [18:0] VEC [8] = '{
        {3'b000, 16'h0000}, {3'b000, 16'hFFFF}, {3'b000, 16'h01A5},
        {3'b100, 16'h1234}, {3'b010, 16'h00C3}, {3'b011, 16'h7F00},
        {3'b110, 16'h8001}, {3'b111, 16'hFE01}
    };

    function automatic logic oddp(input logic [7:0] b);
        return ~(^b);
    endfunction

    function automatic logic [17:0] good_word(input logic [15:0] d);
        return {oddp(d[15:8]), oddp(d[7:0]), d};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        wr_en = 0; wr_byte = 0; wr_lane = 0; wr_data = '0;
        par_invert = 0; err_mask = 0; rd_valid = 0; ram_rd_data = '0;
    endtask

    task automatic do_read(input logic [17:0] w, input logic mask);
        @(negedge clk);
        rd_valid = 1; ram_rd_data = w; err_mask = mask;
        @(negedge clk);
        idle();
    endtask

    initial begin
        idle();
        rst_n = 0;
        repeat (3) @(negedge clk);
        // R1: outputs under reset
        chk("R1 reset", {ram_wr_data, ram_wr_be, bus_valid}, '0);
        chk("R1 reset bus", {14'd0, bus_data}, '0);
        rst_n = 1;
        @(negedge clk);
        chk("R1 after release", {ram_wr_data, ram_wr_be, bus_valid}, '0);

        // R2 R3 R4: vector walk
        for (int k = 0; k < 8; k++) begin
            logic [15:0] d;
            logic inv, byt, ln;
            logic [17:0] ew;
            logic [1:0]  eb;
            {inv, byt, ln, d} = VEC[k];
            wr_en = 1; wr_byte = byt; wr_lane = ln; wr_data = d; par_invert = inv;
            @(negedge clk);
            idle();
            ew = good_word(d) ^ {inv, inv, 16'h0};
            eb = !byt ? 2'b11 : (ln ? 2'b10 : 2'b01);
            chk(inv ? "R4 inverted parity" : "R2 word parity", {14'd0, ram_wr_data}, {14'd0, ew});
            chk(byt ? "R3 lane enable" : "R2 word enable", {30'd0, ram_wr_be}, {30'd0, eb});
        end

        // R8: write idle
        @(negedge clk);
        chk("R8 write idle", {ram_wr_data, ram_wr_be}, '0);

        // R5 R6: clean read
        do_read(good_word(16'hBEEF), 0);
        chk("R5 read valid", {31'd0, bus_valid}, 32'd1);
        chk("R5 R6 clean read", {14'd0, bus_data}, {14'd0, 2'b00, 16'hBEEF});
        // R6: low lane check bit flipped
        do_read(good_word(16'h1357) ^ 18'h10000, 0);
        chk("R6 low lane bad", {14'd0, bus_data}, {14'd0, 2'b11, 16'h1357});
        // R6: high lane data bit flipped
        do_read(good_word(16'h2468) ^ 18'h00800, 0);
        chk("R6 high lane bad", {14'd0, bus_data}, {14'd0, 2'b11, 16'h2C68});
        // R6: both lanes bad
        do_read(good_word(16'h0F0F) ^ 18'h30000, 0);
        chk("R6 both lanes bad", {14'd0, bus_data}, {14'd0, 2'b11, 16'h0F0F});
        // R7: mask hides error, data still passes (R5)
        do_read(good_word(16'hA5A5) ^ 18'h20000, 1);
        chk("R7 masked flags", {14'd0, bus_data}, {14'd0, 2'b00, 16'hA5A5});
        // R8: read idle
        @(negedge clk);
        chk("R8 read idle", {13'd0, bus_valid, bus_data}, '0);

        // R4 then read back planted word -> R6 flags
        wr_en = 1; wr_data = 16'h4321; par_invert = 1;
        @(negedge clk);
        idle();
        do_read(ram_wr_data, 0);
        chk("R4 R6 planted error", {14'd0, bus_data}, {14'd0, 2'b11, 16'h4321});

        // R1: reset during activity
        wr_en = 1; wr_data = 16'hFFFF; rd_valid = 1; ram_rd_data = 18'h3FFFF;
        rst_n = 0;
        @(negedge clk);
        chk("R1 reset mid traffic", {ram_wr_data, ram_wr_be, bus_valid}, '0);
        chk("R1 reset mid bus", {14'd0, bus_data}, '0);
        idle();
        rst_n = 1;
        @(negedge clk);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog all-R act=hung exp=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule